// File: doc/BRIEF.md
# DRAM Refresh Manager with Postponement

This block issues refresh commands for one DRAM channel. A free-running interval timer adds one unit of refresh credit to a pending count at the end of every refresh interval. While credit is pending, the block waits for a cycle in which the scheduler reports an idle command bus and a free target. It then issues the refresh at the lowest priority. If the pending count reaches its configured ceiling, the block stops waiting for idle time and forces the refresh, pre-empting normal traffic.

Two refresh granularities are supported. In all-bank mode, every refresh covers the whole channel and blocks every bank for the all-bank recovery time. In per-bank mode, each refresh names one bank, which is blocked for the shorter per-bank recovery time while the other banks keep serving requests. Banks are chosen in rotating order. A bank the scheduler reports busy is passed over when another eligible bank is free. A hot/alarm input halves the interval, so that every row is covered in half the normal retention period. If credit would be lost because the count is already at its ceiling, a sticky error flag is raised.

Top module: `refresh_mgr`

## Requirements
- R1: While rst_ni is low and right after reset, ref_req_o, ref_forced_o, ovf_o and every bit of blocked_o are 0, and no refresh is issued before the first interval has elapsed.
- R2: In all-bank mode (per_bank_i=0) with hot_i=0, one unit of credit accrues every TREFI cycles. With the bus idle and no bank busy, each unit produces exactly one refresh command.
- R3: With hot_i=1, the interval in use is halved, which doubles the refresh rate in both modes.
- R4: In per-bank mode (per_bank_i=1), the interval is TREFI/NUM_BANKS and each command targets the single bank given on ref_bank_o. In all-bank mode ref_all_o=1, and in per-bank mode ref_all_o=0.
- R5: A refresh that is not forced is issued only when credit is pending, bus_idle_i was 1, and the target bank(s) showed 0 on bank_busy_i. In all-bank mode, that means all banks. Such a refresh has ref_forced_o=0.
- R6: When the pending count equals MAX_PEND, a refresh is issued as soon as its target is not blocked, regardless of bus_idle_i and bank_busy_i. Such a refresh has ref_forced_o=1.
- R7: After an all-bank refresh, blocked_o is all ones for TRFC_AB cycles. After a per-bank refresh, only the refreshed bank's bit is set, for TRFC_PB cycles. No refresh targets a blocked bank.
- R8: Per-bank targets rotate in ascending order from the bank after the last one refreshed, wrapping at NUM_BANKS. A bank with bank_busy_i set is skipped in favour of the next free bank.
- R9: If credit accrues while the count is at MAX_PEND and no refresh issues in that cycle, the count holds and ovf_o rises and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| per_bank_i | input | 1 | 1 selects per-bank refresh, 0 selects all-bank refresh |
| hot_i | input | 1 | High-temperature or hammer alarm; halves the refresh interval |
| bus_idle_i | input | 1 | Scheduler reports the command bus idle this cycle |
| bank_busy_i | input | NUM_BANKS | Scheduler reports a bank busy with pending work |
| ref_req_o | output | 1 | One-cycle refresh command strobe |
| ref_all_o | output | 1 | Command covers all banks (valid with ref_req_o) |
| ref_bank_o | output | $clog2(NUM_BANKS) | Target bank of a per-bank command |
| ref_forced_o | output | 1 | Command was forced by the postponement limit |
| blocked_o | output | NUM_BANKS | Banks still in refresh recovery |
| ovf_o | output | 1 | Sticky flag: refresh credit was lost |

## Verification
A wrong interval count or a mis-sized shift shows up as a wrong number of refresh strobes within a fixed window, within two or three intervals. A pending count that leaks or drifts changes when the first forced strobe appears, and whether ref_forced_o is set on it, after MAX_PEND intervals. A stale rotation pointer or a wrong skip shows in the ref_bank_o sequence by the second or third per-bank command. Recovery timers that are off by one show on blocked_o at the exact cycle they should clear.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic {
    REF_MODE_ALL  = 1'b0,
    REF_MODE_BANK = 1'b1
  } ref_mode_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned TREFI     = 1560,
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  refresh_pkg::ref_mode_e mode_i,
  input  logic                   hot_i,
  output logic                   tick_o
);
  localparam int unsigned CW  = $clog2(TREFI + 1);
  localparam int unsigned BSH = $clog2(NUM_BANKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] base;
  logic [CW-1:0] lim;

  // halve for hot, divide by bank count for per-bank rotation
  always_comb begin
    base = CW'(TREFI);
    if (hot_i) base = base >> 1;
    if (mode_i == refresh_pkg::REF_MODE_BANK) base = base >> BSH;
    lim = (base == '0) ? CW'(1) : base;
  end

  assign tick_o = (cnt_q >= lim - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/ref_pending_ctr.sv
module ref_pending_ctr #(
  parameter int unsigned MAX_PEND = 8,
  localparam int unsigned PW      = $clog2(MAX_PEND + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          issue_i,
  output logic [PW-1:0] pend_o,
  output logic          full_o,
  output logic          ovf_o
);
  assign full_o = (pend_o == PW'(MAX_PEND));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
      ovf_o  <= 1'b0;
    end else if (tick_i && !issue_i) begin
      if (full_o) ovf_o  <= 1'b1;   // credit lost, count saturates
      else        pend_o <= pend_o + PW'(1);
    end else if (!tick_i && issue_i) begin
      pend_o <= pend_o - PW'(1);
    end
  end
endmodule

// File: rtl/ref_block_timer.sv
module ref_block_timer #(
  parameter int unsigned TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          blocked_o
);
  logic [TW-1:0] cnt_q;

  assign blocked_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load_i)    cnt_q <= len_i;
    else if (blocked_o) cnt_q <= cnt_q - TW'(1);
  end
endmodule

// File: rtl/ref_bank_picker.sv
module ref_bank_picker #(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned BW       = $clog2(NUM_BANKS)
) (
  input  logic [BW-1:0]        ptr_i,
  input  logic [NUM_BANKS-1:0] cand_i,
  output logic                 found_o,
  output logic [BW-1:0]        idx_o
);
  // first candidate at or after ptr_i, wrapping
  always_comb begin
    int k;
    k       = 0;
    found_o = 1'b0;
    idx_o   = '0;
    for (int off = 0; off < int'(NUM_BANKS); off++) begin
      k = (int'(ptr_i) + off) % int'(NUM_BANKS);
      if (!found_o && cand_i[k]) begin
        found_o = 1'b1;
        idx_o   = BW'(k);
      end
    end
  end
endmodule

// File: rtl/refresh_mgr.sv
module refresh_mgr #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned TREFI     = 1560,
  parameter int unsigned MAX_PEND  = 8,
  parameter int unsigned TRFC_AB   = 59,
  parameter int unsigned TRFC_PB   = 26,
  localparam int unsigned BW       = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 per_bank_i,
  input  logic                 hot_i,
  input  logic                 bus_idle_i,
  input  logic [NUM_BANKS-1:0] bank_busy_i,
  output logic                 ref_req_o,
  output logic                 ref_all_o,
  output logic [BW-1:0]        ref_bank_o,
  output logic                 ref_forced_o,
  output logic [NUM_BANKS-1:0] blocked_o,
  output logic                 ovf_o
);
  import refresh_pkg::*;

  localparam int unsigned TRFC_MAX = (TRFC_AB > TRFC_PB) ? TRFC_AB : TRFC_PB;
  localparam int unsigned TW       = $clog2(TRFC_MAX + 1);
  localparam int unsigned PW       = $clog2(MAX_PEND + 1);

  ref_mode_e       mode;
  logic            tick;
  logic [PW-1:0]   pend;
  logic            full;
  logic            issue;
  logic            opp;
  logic            frc;
  logic [BW-1:0]   ptr_q;
  logic [BW-1:0]   sel;
  logic            opp_found, frc_found;
  logic [BW-1:0]   opp_idx, frc_idx;
  logic            ab_opp, ab_frc, pb_opp, pb_frc;
  logic [NUM_BANKS-1:0] load;
  logic [TW-1:0]   blk_len;

  assign mode = per_bank_i ? REF_MODE_BANK : REF_MODE_ALL;

  ref_interval_timer #(.TREFI(TREFI), .NUM_BANKS(NUM_BANKS)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .hot_i  (hot_i),
    .tick_o (tick)
  );

  ref_pending_ctr #(.MAX_PEND(MAX_PEND)) i_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .issue_i (issue),
    .pend_o  (pend),
    .full_o  (full),
    .ovf_o   (ovf_o)
  );

  // opportunistic: free and not busy; forced: only not blocked
  ref_bank_picker #(.NUM_BANKS(NUM_BANKS)) i_pick_opp (
    .ptr_i   (ptr_q),
    .cand_i  (~blocked_o & ~bank_busy_i),
    .found_o (opp_found),
    .idx_o   (opp_idx)
  );

  ref_bank_picker #(.NUM_BANKS(NUM_BANKS)) i_pick_frc (
    .ptr_i   (ptr_q),
    .cand_i  (~blocked_o),
    .found_o (frc_found),
    .idx_o   (frc_idx)
  );

  assign ab_opp = bus_idle_i && (blocked_o == '0) && (bank_busy_i == '0);
  assign ab_frc = full && (blocked_o == '0);
  assign pb_opp = bus_idle_i && opp_found;
  assign pb_frc = full && frc_found;

  assign opp   = (pend != '0) && ((mode == REF_MODE_BANK) ? pb_opp : ab_opp);
  assign frc   = !opp && ((mode == REF_MODE_BANK) ? pb_frc : ab_frc);
  assign issue = opp || frc;
  assign sel   = (mode == REF_MODE_BANK) ? (opp ? opp_idx : frc_idx) : '0;

  assign blk_len = (mode == REF_MODE_BANK) ? TW'(TRFC_PB) : TW'(TRFC_AB);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign load[b] = issue && ((mode == REF_MODE_ALL) || (sel == BW'(b)));

    ref_block_timer #(.TW(TW)) i_blk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load[b]),
      .len_i     (blk_len),
      .blocked_o (blocked_o[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_req_o    <= 1'b0;
      ref_forced_o <= 1'b0;
      ref_all_o    <= 1'b0;
      ref_bank_o   <= '0;
      ptr_q        <= '0;
    end else begin
      ref_req_o    <= issue;
      ref_forced_o <= frc;
      if (issue) begin
        ref_all_o  <= (mode == REF_MODE_ALL);
        ref_bank_o <= sel;
        if (mode == REF_MODE_BANK)
          ptr_q <= (sel == BW'(NUM_BANKS - 1)) ? '0 : sel + BW'(1);
      end
    end
  end
endmodule

// File: rtl/refresh_mgr_chk.sv
module refresh_mgr_chk #(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned BW       = $clog2(NUM_BANKS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 per_bank_i,
  input logic                 bus_idle_i,
  input logic                 ref_req_o,
  input logic                 ref_all_o,
  input logic [BW-1:0]        ref_bank_o,
  input logic                 ref_forced_o,
  input logic [NUM_BANKS-1:0] blocked_o,
  input logic                 ovf_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!ref_req_o && !ref_forced_o && !ovf_o && blocked_o == '0); // R1
    end
  end

  AST_MODE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> (ref_all_o == !$past(per_bank_i))); // R4

  AST_OPP_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_forced_o) |-> $past(bus_idle_i)); // R5

  AST_FORCED_IS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_forced_o |-> ref_req_o); // R6

  AST_ALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && ref_all_o) |-> (blocked_o == {NUM_BANKS{1'b1}})); // R7

  AST_ALL_WAS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && ref_all_o) |-> ($past(blocked_o) == '0)); // R7

  AST_BANK_WAS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_all_o) |->
      (($past(blocked_o) & (NUM_BANKS'(1) << ref_bank_o)) == '0)); // R7

  AST_BANK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_all_o) |-> blocked_o[ref_bank_o]); // R7

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R9
endmodule

bind refresh_mgr refresh_mgr_chk #(.NUM_BANKS(NUM_BANKS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .per_bank_i   (per_bank_i),
  .bus_idle_i   (bus_idle_i),
  .ref_req_o    (ref_req_o),
  .ref_all_o    (ref_all_o),
  .ref_bank_o   (ref_bank_o),
  .ref_forced_o (ref_forced_o),
  .blocked_o    (blocked_o),
  .ovf_o        (ovf_o)
);

// File: tb/test_refresh_mgr.sv
`timescale 1ns/1ps
module test_refresh_mgr;
  localparam int NB = 4;

  typedef struct packed {
    logic        pb;
    logic        hot;
    logic        idle;
    logic [3:0]  busy;
    logic [15:0] cycles;
    logic [7:0]  refs;
    logic [7:0]  forced;
    logic        ovf;
  } vec_t;

  // TREFI=64 MAX_PEND=4 TRFC_AB=40 TRFC_PB=3
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 4'h0, 16'd200,  8'd3,  8'd0, 1'b0},  // R2
    '{1'b0, 1'b1, 1'b1, 4'h0, 16'd180,  8'd4,  8'd0, 1'b0},  // R3
    '{1'b1, 1'b0, 1'b1, 4'h0, 16'd200,  8'd12, 8'd0, 1'b0},  // R4
    '{1'b1, 1'b1, 1'b1, 4'h0, 16'd200,  8'd24, 8'd0, 1'b0},  // R3 per-bank
    '{1'b0, 1'b0, 1'b0, 4'h0, 16'd300,  8'd1,  8'd1, 1'b0},  // R6
    '{1'b0, 1'b0, 1'b1, 4'h1, 16'd300,  8'd1,  8'd1, 1'b0},  // R5
    '{1'b1, 1'b0, 1'b1, 4'hF, 16'd300,  8'd15, 8'd15, 1'b0}, // R5
    '{1'b1, 1'b0, 1'b0, 4'h0, 16'd300,  8'd15, 8'd15, 1'b0}  // R6
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          per_bank = 1'b0;
  logic          hot = 1'b0;
  logic          idle = 1'b0;
  logic [NB-1:0] busy = '0;
  logic          ref_req, ref_all, ref_forced, ovf;
  logic [1:0]    ref_bank;
  logic [NB-1:0] blocked;

  int n_tests = 0;
  int n_fail  = 0;
  int n_ref   = 0;
  int n_frc   = 0;
  int bank_log [32];
  int cyc = 0;
  bit mon_en = 1'b0;

  always #2.5 clk = ~clk;

  refresh_mgr #(
    .NUM_BANKS(NB), .TREFI(64), .MAX_PEND(4), .TRFC_AB(40), .TRFC_PB(3)
  ) i_refresh_mgr (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .per_bank_i   (per_bank),
    .hot_i        (hot),
    .bus_idle_i   (idle),
    .bank_busy_i  (busy),
    .ref_req_o    (ref_req),
    .ref_all_o    (ref_all),
    .ref_bank_o   (ref_bank),
    .ref_forced_o (ref_forced),
    .blocked_o    (blocked),
    .ovf_o        (ovf)
  );

  always @(negedge clk) begin
    if (mon_en && ref_req) begin
      if (n_ref < 32) bank_log[n_ref] = int'(ref_bank);
      n_ref++;
      if (ref_forced) n_frc++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input logic pb, input logic ht, input logic idl, input logic [NB-1:0] bsy);
    rst_n = 1'b0; mon_en = 1'b0;
    per_bank = pb; hot = ht; idle = idl; busy = bsy;
    repeat (3) @(negedge clk);
    n_ref = 0; n_frc = 0;
    mon_en = 1'b1;
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_ref();
    do @(negedge clk); while (!ref_req);
  endtask

  function automatic string vtag(input int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R3";
      4: return "R6";
      5: return "R5";
      6: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    // R1: reset state
    start(1'b0, 1'b0, 1'b1, '0);
    rst_n = 1'b0;
    @(negedge clk);
    check(!ref_req && !ref_forced && !ovf && blocked == '0, "R1 reset outputs",
          int'({ref_req, ref_forced, ovf, blocked}), 0);
    start(1'b0, 1'b0, 1'b1, '0);
    run(60);
    check(n_ref == 0, "R1 no early refresh", n_ref, 0);

    for (int i = 0; i < NV; i++) begin
      start(VECS[i].pb, VECS[i].hot, VECS[i].idle, VECS[i].busy);
      run(int'(VECS[i].cycles));
      check(n_ref == int'(VECS[i].refs), {vtag(i), " refresh count"}, n_ref, int'(VECS[i].refs));
      check(n_frc == int'(VECS[i].forced), {vtag(i), " forced count"}, n_frc, int'(VECS[i].forced));
      check(ovf == VECS[i].ovf, {vtag(i), " error flag"}, int'(ovf), int'(VECS[i].ovf));
    end

    // R8: rotation
    start(1'b1, 1'b0, 1'b1, '0);
    run(90);
    check(n_ref == 5, "R8 rotation count", n_ref, 5);
    for (int j = 0; j < 5; j++)
      check(bank_log[j] == (j % 4), "R8 rotation order", bank_log[j], j % 4);

    // R8: skip busy bank 1
    start(1'b1, 1'b0, 1'b1, 4'b0010);
    run(90);
    begin
      int exp_b [5] = '{0, 2, 3, 0, 2};
      for (int j = 0; j < 5; j++)
        check(bank_log[j] == exp_b[j], "R8 skip busy", bank_log[j], exp_b[j]);
    end

    // R7: per-bank recovery window
    start(1'b1, 1'b0, 1'b1, '0);
    wait_ref();
    check(blocked == 4'b0001 && !ref_all, "R7 per-bank block set", int'(blocked), 1);
    run(2);
    check(blocked == 4'b0001, "R7 per-bank block held", int'(blocked), 1);
    run(1);
    check(blocked == 4'b0000, "R7 per-bank block cleared", int'(blocked), 0);

    // R7: all-bank recovery window
    start(1'b0, 1'b0, 1'b1, '0);
    wait_ref();
    check(blocked == 4'b1111 && ref_all, "R7 all-bank block set", int'(blocked), 15);
    run(39);
    check(blocked == 4'b1111, "R7 all-bank block held", int'(blocked), 15);
    run(1);
    check(blocked == 4'b0000, "R7 all-bank block cleared", int'(blocked), 0);

    // R9: hot all-bank outruns recovery, credit lost, flag sticky
    start(1'b0, 1'b1, 1'b1, '0);
    run(1500);
    check(ovf == 1'b1, "R9 overflow raised", int'(ovf), 1);
    hot = 1'b0;
    run(300);
    check(ovf == 1'b1, "R9 overflow sticky", int'(ovf), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule